// File: doc/BRIEF.md
# Potentiometer Data Register Bank and Transfer Sequencer

This block keeps the stored settings of a four-channel digital potentiometer and runs the commands that move those settings around. Every channel owns four 8-bit data registers, so the bank holds 16 bytes. The block also holds the four wiper registers that set the tap positions. A serial front end decodes the host command and hands over one strobe with an opcode, a channel select, a register select and, when needed, a data byte. The front end also forwards a pulse when it sees the bus stop condition.

Copying a data register into a wiper register is a volatile move and takes effect on the next clock. Host writes to a data register, and copies from a wiper register into a data register, behave like nonvolatile programming. The sequencer stages them, waits for the stop pulse, and then raises a busy flag for a fixed number of clocks. The front end answers acknowledge polling from that busy flag. The stored byte changes only when the write cycle finishes. Global variants copy all four channels at once, using one register index, and a global store costs one write cycle.

Reset stands in for power-up. The stored bytes survive reset. In the first clock after reset is released, each channel's wiper is loaded from its register 0.

Top module: `dcp_regbank`

## Requirements
- R1: The bank holds 16 bytes, addressed by channel `cmd_pot` (0..3) and register `cmd_reg` (0..3). A read command (`cmd_op`=1) accepted at a clock edge raises `rd_valid_o` for exactly the following cycle, with `rd_data_o` equal to the addressed byte.
- R2: A host write (`cmd_op`=2) stages `cmd_wdata` and does not change the bank or raise `busy_o` until `stop_i` is seen. After that, `busy_o` stays high for exactly `WR_CYCLES` cycles, and the new byte can be read once it falls.
- R3: `busy_o` rises only in the cycle after `stop_i` is sampled while a nonvolatile command is pending. A `stop_i` pulse with nothing pending leaves `busy_o` low.
- R4: A channel load (`cmd_op`=3) copies register `cmd_reg` of channel `cmd_pot` into that channel's wiper in the cycle after the command. The other wipers are unchanged and `busy_o` stays low. Wiper p appears on `wiper_o[8p+7:8p]`.
- R5: A channel store (`cmd_op`=4) captures the wiper of `cmd_pot` at command time and writes it into register `cmd_reg` of that channel at the end of one write cycle.
- R6: A global load (`cmd_op`=5) copies register `cmd_reg` of every channel into that channel's wiper in the cycle after the command.
- R7: A global store (`cmd_op`=6) writes every wiper into register `cmd_reg` of its own channel. It uses a single write cycle of `WR_CYCLES` busy cycles.
- R8: Command strobes are ignored while a nonvolatile command waits for `stop_i` or while `busy_o` is high. An ignored read gives no `rd_valid_o`, and an ignored load leaves the wipers unchanged.
- R9: While `rst` is high, every wiper reads 0 and `busy_o` and `rd_valid_o` are low. In the first cycle after release, every wiper equals its channel's register 0. The stored bytes are kept across reset.
- R10: A reset during a write cycle abandons that write, and the targeted byte keeps its old value.
- R11: Before any write, every stored byte equals parameter `DR_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; power-up stand-in |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Opcode: 1 read, 2 write, 3 load, 4 store, 5 global load, 6 global store |
| cmd_pot | input | 2 | Channel select |
| cmd_reg | input | 2 | Data register select |
| cmd_wdata | input | DATA_W | Byte for host write |
| stop_i | input | 1 | Stop-condition pulse from the serial front end |
| busy_o | output | 1 | Nonvolatile write cycle in progress |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DATA_W | Read data |
| wiper_o | output | 4*DATA_W | Four wiper registers, channel 0 in the low byte |

## Verification
The bench builds the block with `WR_CYCLES`=4 and `DR_INIT`=0x2A. The short write cycle makes it cheap to program and read back all 16 registers and to count the exact busy length after every store. The non-default initial byte tells the preset contents apart from the reset-cleared wipers. With these values, the bench can sweep every channel and register combination for loads and both global transfers. It can also reset in the middle of a write cycle and check that the target byte stays unchanged.

// File: rtl/dcp_bank_pkg.sv
package dcp_bank_pkg;

    localparam int NPOT   = 4;
    localparam int NREG   = 4;
    localparam int PSEL_W = $clog2(NPOT);
    localparam int RSEL_W = $clog2(NREG);

    typedef logic [PSEL_W-1:0] pot_sel_t;
    typedef logic [RSEL_W-1:0] reg_sel_t;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_RD_DR     = 3'd1,
        OP_WR_DR     = 3'd2,
        OP_DR_TO_W   = 3'd3,
        OP_W_TO_DR   = 3'd4,
        OP_G_DR_TO_W = 3'd5,
        OP_G_W_TO_DR = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        SQ_RECALL,
        SQ_IDLE,
        SQ_ARMED,
        SQ_WRITE
    } sq_state_e;

    typedef struct packed {
        logic [NPOT-1:0] pot_mask;
        reg_sel_t        reg_sel;
    } nv_job_t;

    function automatic logic [NPOT-1:0] pot_onehot(input pot_sel_t sel);
        logic [NPOT-1:0] m;
        m = '0;
        m[sel] = 1'b1;
        return m;
    endfunction

    function automatic logic is_nv_op(input op_e op);
        return (op == OP_WR_DR) || (op == OP_W_TO_DR) || (op == OP_G_W_TO_DR);
    endfunction

endpackage

// File: rtl/dcp_nv_array.sv
module dcp_nv_array
    import dcp_bank_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic                   clk,
    input  logic [NPOT-1:0]        we_mask,
    input  reg_sel_t               wr_sel,
    input  logic [NPOT*DATA_W-1:0] wr_row,
    input  reg_sel_t               rd_sel,
    output logic [NPOT*DATA_W-1:0] rd_row
);

    // Storage is deliberately never reset: its contents model nonvolatile cells.
    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        logic [DATA_W-1:0] cells [NREG];

        initial begin
            for (int r = 0; r < NREG; r++) cells[r] = INIT;
        end

        always @(posedge clk) begin
            if (we_mask[p]) cells[wr_sel] <= wr_row[p*DATA_W +: DATA_W];
        end

        assign rd_row[p*DATA_W +: DATA_W] = cells[rd_sel];
    end

endmodule

// File: rtl/dcp_wiper_bank.sv
module dcp_wiper_bank
    import dcp_bank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPOT-1:0]        ld_mask,
    input  logic [NPOT*DATA_W-1:0] ld_row,
    output logic [NPOT*DATA_W-1:0] wiper_row
);

    for (genvar p = 0; p < NPOT; p++) begin : g_wcr
        logic [DATA_W-1:0] wcr_q;

        always_ff @(posedge clk) begin
            if (rst)             wcr_q <= '0;
            else if (ld_mask[p]) wcr_q <= ld_row[p*DATA_W +: DATA_W];
        end

        assign wiper_row[p*DATA_W +: DATA_W] = wcr_q;
    end

endmodule

// File: rtl/dcp_nv_timer.sv
module dcp_nv_timer #(
    parameter int WR_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(WR_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    // R2: the remaining count never exceeds the programmed cycle length
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (int'(cnt_q) < WR_CYCLES));

endmodule

// File: rtl/dcp_regbank.sv
module dcp_regbank
    import dcp_bank_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                WR_CYCLES = 50000,
    parameter logic [DATA_W-1:0] DR_INIT   = DATA_W'(32)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [PSEL_W-1:0]      cmd_pot,
    input  logic [RSEL_W-1:0]      cmd_reg,
    input  logic [DATA_W-1:0]      cmd_wdata,
    input  logic                   stop_i,
    output logic                   busy_o,
    output logic                   rd_valid_o,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic [NPOT*DATA_W-1:0] wiper_o
);

    localparam int ROW_W = NPOT * DATA_W;

    sq_state_e        state_q;
    nv_job_t          job_q;
    logic [ROW_W-1:0] stage_q;
    logic [ROW_W-1:0] dr_row;
    logic [NPOT-1:0]  ld_mask;
    logic [NPOT-1:0]  we_mask;
    reg_sel_t         rd_sel;
    op_e              op;
    logic             accept;
    logic             nv_start;
    logic             nv_done;
    logic             nv_busy;

    assign op       = op_e'(cmd_op);
    assign accept   = cmd_valid && (state_q == SQ_IDLE);
    assign nv_start = (state_q == SQ_ARMED) && stop_i;
    assign rd_sel   = (state_q == SQ_RECALL) ? '0 : reg_sel_t'(cmd_reg);
    assign we_mask  = nv_done ? job_q.pot_mask : '0;

    always_comb begin
        ld_mask = '0;
        if (state_q == SQ_RECALL && !rst)
            ld_mask = '1;
        else if (accept && op == OP_DR_TO_W)
            ld_mask = pot_onehot(pot_sel_t'(cmd_pot));
        else if (accept && op == OP_G_DR_TO_W)
            ld_mask = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_RECALL;
        end else begin
            case (state_q)
                SQ_RECALL: state_q <= SQ_IDLE;
                SQ_IDLE:   if (accept && is_nv_op(op)) state_q <= SQ_ARMED;
                SQ_ARMED:  if (stop_i)  state_q <= SQ_WRITE;
                SQ_WRITE:  if (nv_done) state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q   <= '0;
            stage_q <= '0;
        end else if (accept && is_nv_op(op)) begin
            job_q.reg_sel  <= reg_sel_t'(cmd_reg);
            job_q.pot_mask <= (op == OP_G_W_TO_DR) ? '1 : pot_onehot(pot_sel_t'(cmd_pot));
            stage_q        <= (op == OP_WR_DR) ? {NPOT{cmd_wdata}} : wiper_o;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= accept && (op == OP_RD_DR);
            if (accept && op == OP_RD_DR)
                rd_data_o <= dr_row[cmd_pot*DATA_W +: DATA_W];
        end
    end

    dcp_nv_array #(.DATA_W(DATA_W), .INIT(DR_INIT)) u_array (
        .clk     (clk),
        .we_mask (we_mask),
        .wr_sel  (job_q.reg_sel),
        .wr_row  (stage_q),
        .rd_sel  (rd_sel),
        .rd_row  (dr_row)
    );

    dcp_wiper_bank #(.DATA_W(DATA_W)) u_wipers (
        .clk       (clk),
        .rst       (rst),
        .ld_mask   (ld_mask),
        .ld_row    (dr_row),
        .wiper_row (wiper_o)
    );

    dcp_nv_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (nv_start),
        .busy  (nv_busy),
        .done  (nv_done)
    );

    assign busy_o = nv_busy;

    // R3: busy only starts after a stop pulse
    p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    // R8: a strobe during busy yields no read response
    p_no_read_when_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cmd_valid) |=> !rd_valid_o);

    // R8: wipers cannot move while a write cycle runs
    p_wiper_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(wiper_o));

    // R1: read responses follow a strobe
    p_read_needs_cmd_r1: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(cmd_valid));

    // R9: the release cycle recalls register 0 into every wiper
    p_recall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (wiper_o == $past(dr_row)));

endmodule

// File: tb/dcp_regbank_tb_top.sv
module dcp_regbank_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         WRC        = 4;
    localparam logic [7:0] INIT_B     = 8'h2A;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [1:0] cmd_pot;
    logic [1:0] cmd_reg;
    logic [7:0] cmd_wdata;
    logic       stop_i;
    logic       busy_o;
    logic       rd_valid_o;
    logic [7:0] rd_data_o;
    logic [31:0] wiper_o;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;
    logic [7:0] exp_mem [16];
    logic [7:0] exp_wip [4];

    dcp_regbank #(.DATA_W(8), .WR_CYCLES(WRC), .DR_INIT(INIT_B)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .stop_i(stop_i), .busy_o(busy_o), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o), .wiper_o(wiper_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cmd(input int op, input int p, input int r, input int d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pot = 2'(p); cmd_reg = 2'(r); cmd_wdata = 8'(d);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic stop_pulse();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy_o && n < 100) begin n++; @(negedge clk); end
        check(n == WRC, req, n, WRC);
    endtask

    task automatic rd_check(input int p, input int r, input string req);
        cmd(1, p, r, 0);
        check(rd_valid_o == 1'b1, req, rd_valid_o, 1);
        check(rd_data_o == exp_mem[p*4+r], req, rd_data_o, exp_mem[p*4+r]);
    endtask

    task automatic wip_check(input string req);
        for (int p = 0; p < 4; p++)
            check(wiper_o[p*8 +: 8] == exp_wip[p], req, wiper_o[p*8 +: 8], exp_wip[p]);
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_pot = '0; cmd_reg = '0;
        cmd_wdata = '0; stop_i = 1'b0;
        for (int i = 0; i < 16; i++) exp_mem[i] = INIT_B;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy_o == 1'b0, "R9 busy in reset", busy_o, 0);
        check(rd_valid_o == 1'b0, "R9 rd_valid in reset", rd_valid_o, 0);
        check(wiper_o == '0, "R9 wipers in reset", wiper_o, 0);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 4; p++) exp_wip[p] = INIT_B;
        wip_check("R9 recall R11");

        // R11 R1: preset contents everywhere
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) rd_check(p, r, "R11 R1 preset");

        // R2: program every register
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                int v = (p * 16 + r * 5 + 8'h41) & 8'hFF;
                cmd(2, p, r, v);
                if (p == 0 && r == 0) begin
                    repeat (3) @(negedge clk);
                    check(busy_o == 1'b0, "R2 no busy before stop", busy_o, 0);
                end
                stop_pulse();
                wait_idle("R2 busy length");
                exp_mem[p*4+r] = 8'(v);
            end
        end
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) rd_check(p, r, "R2 R1 readback");

        // R3: stop with nothing pending
        stop_pulse();
        check(busy_o == 1'b0, "R3 idle stop", busy_o, 0);
        @(negedge clk);
        check(busy_o == 1'b0, "R3 idle stop later", busy_o, 0);

        // R4: single loads
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                cmd(3, p, r, 0);
                exp_wip[p] = exp_mem[p*4+r];
                check(busy_o == 1'b0, "R4 no busy", busy_o, 0);
                wip_check("R4 load");
            end
        end

        // R6: global loads
        for (int r = 0; r < 4; r++) begin
            cmd(5, 0, r, 0);
            for (int p = 0; p < 4; p++) exp_wip[p] = exp_mem[p*4+r];
            wip_check("R6 global load");
        end

        // R5 and R8: single store with an ignored load while armed
        cmd(5, 0, 1, 0);
        for (int p = 0; p < 4; p++) exp_wip[p] = exp_mem[p*4+1];
        for (int p = 0; p < 4; p++) begin
            cmd(4, p, 3, 0);
            cmd(3, p, 0, 0);
            wip_check("R8 load ignored while armed");
            stop_pulse();
            wait_idle("R5 busy length");
            exp_mem[p*4+3] = exp_wip[p];
            rd_check(p, 3, "R5 store");
        end

        // R7: global store after distinct loads
        for (int p = 0; p < 4; p++) begin
            cmd(3, p, (p + 2) % 4, 0);
            exp_wip[p] = exp_mem[p*4+((p+2)%4)];
        end
        wip_check("R7 setup");
        cmd(6, 1, 2, 0);
        stop_pulse();
        wait_idle("R7 single write cycle");
        for (int p = 0; p < 4; p++) exp_mem[p*4+2] = exp_wip[p];
        for (int p = 0; p < 4; p++) rd_check(p, 2, "R7 global store");

        // R8: read strobe during busy
        cmd(2, 1, 1, 8'hC3);
        stop_pulse();
        cmd(1, 1, 1, 0);
        check(rd_valid_o == 1'b0, "R8 read ignored while busy", rd_valid_o, 0);
        while (busy_o) @(negedge clk);
        exp_mem[5] = 8'hC3;
        rd_check(1, 1, "R8 R2 write after busy");

        // R10 R9: reset during a write cycle
        cmd(2, 3, 2, 8'h99);
        stop_pulse();
        check(busy_o == 1'b1, "R10 busy started", busy_o, 1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0, "R10 busy cleared", busy_o, 0);
        for (int p = 0; p < 4; p++) exp_wip[p] = exp_mem[p*4];
        wip_check("R9 recall after reset keeps contents");
        rd_check(3, 2, "R10 aborted write");
        rd_check(1, 1, "R9 contents kept");

        summary();
        $finish;
    end

endmodule